// File: doc/BRIEF.md
# Fixed-Pattern Branch Predictor

This block predicts the direction of conditional branches for a loop whose outcome sequence is known in advance and repeats forever. It takes no feedback about what the branch actually did. A position counter steps once for each conditional branch and wraps at the end of a pattern fixed at elaboration. The prediction is the pattern bit at the current position. On the sequence it was built for, every branch is predicted correctly.

For comparison, an elaboration-time mode swaps in a 2-bit saturating counter. That counter learns from the actual outcome input. In the fixed-pattern mode the outcome input is present on the port list but has no effect.

The prediction is combinational from the registered state. A consumer therefore reads it in the same cycle in which it raises the branch strobe.

Top module: `branch_pattern_predictor`

## Requirements
- R1: In pattern mode, after reset and before any branch, `predict_taken` equals pattern bit 0. Bit k of `PATTERN` is the prediction for the k-th branch of each period.
- R2: `predict_taken` is 1 for a taken prediction and 0 for not taken. It is valid in the same cycle as `branch_valid`, without waiting for a clock edge.
- R3: In pattern mode, the position advances by exactly one on each rising clock edge where `branch_valid` is 1. It holds on every other edge.
- R4: After the last position (`PAT_LEN`-1), the next branch returns the position to 0.
- R5: With the default parameters (`PAT_LEN`=4, `PATTERN`=4'b1011), successive branches are predicted 1,1,0,1 and then repeat.
- R6: With `PAT_LEN`=5 and `PATTERN`=5'b00111, successive branches are predicted 1,1,1,0,0 and then repeat.
- R7: In pattern mode, `actual_taken` has no effect on `predict_taken` at any time.
- R8: Outcomes that follow the pattern are predicted with 100% accuracy. Outcomes that follow the bitwise-inverted pattern are predicted with 0% accuracy.
- R9: In counter mode (`MODE`=MODE_COUNTER), reset puts the 2-bit level at 0, which is strongly not taken. `predict_taken` is 1 only at levels 2 and 3.
- R10: In counter mode, a branch with `actual_taken`=1 raises the level by one, saturating at 3. A branch with `actual_taken`=0 lowers it by one, saturating at 0. With no branch, the level holds.
- R11: Asserting `rst_n` low at any point returns the state to its reset value. In pattern mode that is position 0; in counter mode it is level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| branch_valid | input | 1 | The current instruction is a conditional branch |
| actual_taken | input | 1 | Resolved outcome of the branch; used only in counter mode |
| predict_taken | output | 1 | Prediction: 1 taken, 0 not taken |

## Verification
The bench elaborates three copies of the block side by side, all driven by the same strobe and outcome.

- The default four-long pattern brings the power-of-two wrap within reach.
- A five-long pattern covers the non-power-of-two case, where the position counter has unused codes and must wrap early.
- A counter-mode copy reaches both saturation limits and the weak/strong transitions.

Random strobe gaps exercise the hold behaviour, and random outcomes confirm that feedback is ignored in pattern mode. Directed runs with matching and inverted outcome streams measure the accuracy at both extremes.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

    typedef enum logic {
        MODE_PATTERN = 1'b0,
        MODE_COUNTER = 1'b1
    } pred_mode_e;

    localparam logic [1:0] LVL_STRONG_NT = 2'd0;
    localparam logic [1:0] LVL_WEAK_NT   = 2'd1;
    localparam logic [1:0] LVL_WEAK_T    = 2'd2;
    localparam logic [1:0] LVL_STRONG_T  = 2'd3;

    typedef struct packed {
        logic [1:0] level;
    } sat_state_t;

endpackage

// File: rtl/bpp_pattern_seq.sv
module bpp_pattern_seq #(
    parameter int              PAT_LEN = 4,
    parameter logic [PAT_LEN-1:0] PATTERN = 4'b1011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic guess
);
    localparam int CNT_BITS = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
    localparam logic [CNT_BITS-1:0] LAST_POS = CNT_BITS'(PAT_LEN - 1);

    typedef struct packed {
        logic [CNT_BITS-1:0] pos;
    } seq_state_t;

    seq_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (step) begin
            if (state_q.pos == LAST_POS) begin
                state_d.pos = '0;
            end else begin
                state_d.pos = state_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign guess = PATTERN[state_q.pos];

    // R3: no branch, no movement
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q.pos));

    // R3: one position per branch below the end
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state_q.pos != LAST_POS) |=>
            state_q.pos == CNT_BITS'($past(state_q.pos) + 1'b1));

    // R4: wrap to the start
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state_q.pos == LAST_POS) |=> state_q.pos == '0);

    // R4: position never leaves the pattern
    a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.pos <= LAST_POS);

endmodule

// File: rtl/bpp_sat_counter.sv
module bpp_sat_counter
    import bpp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic outcome,
    output logic guess
);
    sat_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (step) begin
            if (outcome) begin
                if (state_q.level != LVL_STRONG_T) begin
                    state_d.level = state_q.level + 2'd1;
                end
            end else begin
                if (state_q.level != LVL_STRONG_NT) begin
                    state_d.level = state_q.level - 2'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.level <= LVL_STRONG_NT;
        end else begin
            state_q <= state_d;
        end
    end

    assign guess = (state_q.level == LVL_WEAK_T) || (state_q.level == LVL_STRONG_T);

    // R10: level holds without a branch
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q.level));

    // R10: saturate high
    a_r10_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (step && outcome && state_q.level == LVL_STRONG_T) |=> state_q.level == LVL_STRONG_T);

    // R10: saturate low
    a_r10_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !outcome && state_q.level == LVL_STRONG_NT) |=> state_q.level == LVL_STRONG_NT);

    // R10: taken below the top climbs by one
    a_r10_climb: assert property (@(posedge clk) disable iff (!rst_n)
        (step && outcome && state_q.level != LVL_STRONG_T) |=>
            state_q.level == 2'($past(state_q.level) + 2'd1));

endmodule

// File: rtl/branch_pattern_predictor.sv
module branch_pattern_predictor
    import bpp_pkg::*;
#(
    parameter pred_mode_e         MODE    = MODE_PATTERN,
    parameter int                 PAT_LEN = 4,
    parameter logic [PAT_LEN-1:0] PATTERN = 4'b1011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic branch_valid,
    input  logic actual_taken,
    output logic predict_taken
);
    generate
        if (MODE == MODE_PATTERN) begin : g_pattern
            logic unused_outcome;
            assign unused_outcome = actual_taken;

            bpp_pattern_seq #(
                .PAT_LEN (PAT_LEN),
                .PATTERN (PATTERN)
            ) i_seq (
                .clk   (clk),
                .rst_n (rst_n),
                .step  (branch_valid),
                .guess (predict_taken)
            );
        end else begin : g_counter
            bpp_sat_counter i_ctr (
                .clk     (clk),
                .rst_n   (rst_n),
                .step    (branch_valid),
                .outcome (actual_taken),
                .guess   (predict_taken)
            );
        end
    endgenerate

    // R2: prediction is always a defined bit once out of reset
    a_r2_defined: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(predict_taken));

endmodule

// File: tb/test_branch_pattern_predictor.sv
module test_branch_pattern_predictor;
    import bpp_pkg::*;

    localparam time HALF = 2ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic br = 1'b0;
    logic act = 1'b0;
    logic p4, p5, pc;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int m4 = 0;
    int m5 = 0;
    int mc = 0;

    always #HALF clk = ~clk;

    branch_pattern_predictor i_branch_pattern_predictor (
        .clk(clk), .rst_n(rst_n), .branch_valid(br), .actual_taken(act), .predict_taken(p4));

    branch_pattern_predictor #(.MODE(MODE_PATTERN), .PAT_LEN(5), .PATTERN(5'b00111))
        i_branch_pattern_predictor_five (
        .clk(clk), .rst_n(rst_n), .branch_valid(br), .actual_taken(act), .predict_taken(p5));

    branch_pattern_predictor #(.MODE(MODE_COUNTER))
        i_branch_pattern_predictor_ctr (
        .clk(clk), .rst_n(rst_n), .branch_valid(br), .actual_taken(act), .predict_taken(pc));

    function automatic bit want4(int p);
        return (p % 4) != 2;      // 1,1,0,1
    endfunction

    function automatic bit want5(int p);
        return (p % 5) < 3;       // 1,1,1,0,0
    endfunction

    function automatic bit want_ctr(int lvl);
        return lvl >= 2;
    endfunction

    task automatic check(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " pattern4"}, p4, want4(m4));
        check({tag, " pattern5"}, p5, want5(m5));
        check({tag, " counter"},  pc, want_ctr(mc));
    endtask

    task automatic step(input bit b, input bit a, input string tag, output bit o4, output bit o5);
        @(negedge clk);
        br  = b;
        act = a;
        #1;
        check_all(tag);
        o4 = p4;
        o5 = p5;
        @(posedge clk);
        if (b) begin
            m4 = (m4 + 1) % 4;
            m5 = (m5 + 1) % 5;
            if (a) mc = (mc < 3) ? mc + 1 : 3;
            else   mc = (mc > 0) ? mc - 1 : 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        br = 1'b0;
        rst_n = 1'b0;
        m4 = 0; m5 = 0; mc = 0;
        #1;
        check("R11 R1 reset pattern4", p4, 1'b1);
        check("R11 R1 reset pattern5", p5, 1'b1);
        check("R11 R9 reset counter", pc, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(HALF * 2 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        bit o4, o5;
        int hits4, hits5;
        void'($urandom(32'd20111220));

        do_reset();

        // R5 R6 R2: directed walk over two periods
        for (int k = 0; k < 11; k++) step(1'b1, 1'b0, "R5 R6 R2 directed", o4, o5);

        // R3: gaps hold the position
        step(1'b0, 1'b1, "R3 hold", o4, o5);
        step(1'b0, 1'b0, "R3 hold", o4, o5);
        step(1'b1, 1'b1, "R3 resume", o4, o5);

        // R9 R10: counter climbs to saturation then falls to saturation
        for (int k = 0; k < 5; k++) step(1'b1, 1'b1, "R10 R9 climb", o4, o5);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, "R10 R9 fall", o4, o5);

        // R3 R4 R7 R10: random strobe and outcome
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 3) != 0, $urandom % 2, "R3 R4 R7 R10 random", o4, o5);
        end

        // R11: reset in the middle of a run
        for (int k = 0; k < 3; k++) step(1'b1, 1'b1, "R11 prewalk", o4, o5);
        do_reset();

        // R8: matching outcomes
        hits4 = 0; hits5 = 0;
        for (int k = 0; k < 20; k++) begin
            step(1'b1, want4(k), "R8 match4", o4, o5);
            if (o4 == want4(k)) hits4++;
        end
        check("R8 match accuracy pattern4", hits4 == 20, 1'b1);
        do_reset();
        for (int k = 0; k < 20; k++) begin
            step(1'b1, want5(k), "R8 match5", o4, o5);
            if (o5 == want5(k)) hits5++;
        end
        check("R8 match accuracy pattern5", hits5 == 20, 1'b1);

        // R8: inverted outcomes, R7 feedback ignored
        do_reset();
        hits4 = 0;
        for (int k = 0; k < 20; k++) begin
            step(1'b1, !want4(k), "R8 R7 invert4", o4, o5);
            if (o4 == !want4(k)) hits4++;
        end
        check("R8 inverted accuracy pattern4", hits4 == 0, 1'b1);
        do_reset();
        hits5 = 0;
        for (int k = 0; k < 20; k++) begin
            step(1'b1, !want5(k), "R8 R7 invert5", o4, o5);
            if (o5 == !want5(k)) hits5++;
        end
        check("R8 inverted accuracy pattern5", hits5 == 0, 1'b1);

        summary();
    end

endmodule